// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Aligner

This block sits behind an E1 basic frame aligner. It locks onto the CRC-4 multiframe and decides whether the far end sends CRC-4 at all. The basic aligner hands it three things: a one-cycle strobe for each frame, taken at bit 1 of timeslot 0 with the received bit valid; a level that marks the current frame as a non-frame-alignment (NFAS) frame; and an active-low basic sync flag. The aligner reads only the bit 1 values of NFAS frames. It searches them for the six-bit multiframe alignment sequence 001011. After two back-to-back sequences arrive without error, it declares CRC-4 sync and runs a 16-frame multiframe counter.

The block also handles automatic interworking with far ends that have no CRC-4 capability. A frame timer starts when basic alignment is reached. If CRC-4 sync has not come when the timer expires, and the interworking feature is enabled, the far end is classed as non-CRC-4. The block then drops the receive CRC-4 enable and tells the transmitter to send all E-bits as zero. This decision persists until the system clears it. The CRC-4 checksum itself is computed elsewhere, so this block does not check it.

Top module: `e1_crc4_mf_align`

## Requirements
- R1: After reset, crc_sync_n is 1, mf_count is 0, far_no_crc4 is 0, rx_crc4_en is 0 and tx_ebit_zero is 0.
- R2: While basic_sync_n is 1, no search takes place. Alignment sequences presented in that time neither produce CRC-4 sync nor count toward it.
- R3: Frames are numbered 0 to 15, and NFAS frames have odd numbers. The alignment sequence is 0,0,1,0,1,1 in bit 1 of NFAS frames 1,3,5,7,9,11, oldest first. The bits of frames 13 and 15 and all bits of FAS frames are ignored.
- R4: crc_sync_n goes to 0 one clock after the frame strobe of frame 11 that completes the second of two consecutive error-free sequences. One sequence alone never gives sync.
- R5: If a bit mismatches during the second sequence, the search resumes and slides forward one NFAS frame at a time. Sync then needs two further consecutive sequences.
- R6: While crc_sync_n is 0, mf_count holds the number of the frame whose strobe comes next. It is 12 right after sync is declared, rises by one on each frame strobe and wraps from 15 to 0. It is 0 while unsynchronised.
- R7: One clock after basic_sync_n is 1, crc_sync_n is 1 and mf_count is 0. The search then restarts with an empty history, so sync again needs two full sequences.
- R8: With auto_iw_n at 0, if CRC-4 sync is not reached, far_no_crc4 rises one clock after the TIMEOUT_FRAMES-th frame strobe counted since basic_sync_n went to 0. The default is 3200 frames (400 ms).
- R9: While far_no_crc4 is 1, rx_crc4_en is 0 and tx_ebit_zero is 1.
- R10: While auto_iw_n is 1, far_no_crc4 never rises.
- R11: far_no_crc4 stays at 1 through loss of basic sync until a one-cycle pulse on iw_clear. That pulse clears it one clock later and restarts the period.
- R12: If CRC-4 sync is reached within the period, rx_crc4_en is 1 and far_no_crc4 stays 0, however long the link then runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| basic_sync_n | input | 1 | Basic frame alignment held, active low |
| frame_stb | input | 1 | One-cycle strobe per frame at timeslot 0 bit 1 |
| nfas_frame | input | 1 | Current frame is an NFAS (odd) frame |
| rx_bit | input | 1 | Received bit, valid with frame_stb |
| auto_iw_n | input | 1 | Automatic interworking enable, active low |
| iw_clear | input | 1 | Clears the non-CRC-4 decision and restarts the period |
| crc_sync_n | output | 1 | CRC-4 multiframe sync, active low |
| mf_count | output | 4 | Next frame number within the multiframe |
| far_no_crc4 | output | 1 | Far end classified as non-CRC-4 |
| rx_crc4_en | output | 1 | Receive CRC-4 processing enable |
| tx_ebit_zero | output | 1 | Force transmitted E-bits to zero |

## Verification
The bench places the error in the middle of the confirming multiframe. A design that accepts any two sequences, rather than two consecutive ones, would then declare sync a multiframe too early. It also drops basic alignment after a partial history has built up, which catches a design that keeps stale bits and matches after four NFAS frames. The interworking timer is probed one frame before and exactly at its limit, which exposes off-by-one counting. The non-CRC-4 decision is tested for persistence through basic loss, and the auto-disabled case confirms that no decision is made at all.

// File: rtl/crc4mf_pkg.sv
package crc4mf_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_SYNCED  = 2'd2
  } mf_state_t;

  localparam int          SEQ_LEN    = 6;
  localparam logic [5:0]  MFAS_SEQ   = 6'b001011;
  localparam int          MF_FRAMES  = 16;
  localparam int          POS_W      = $clog2(MF_FRAMES);
  // frame number carrying the last sequence bit
  localparam int          LAST_SEQ_FR = 2 * SEQ_LEN - 1;

  // expected bit for an odd frame number inside the sequence span
  function automatic logic seq_bit(input logic [POS_W-1:0] fnum);
    int idx;
    idx = SEQ_LEN - 1 - int'(fnum[POS_W-1:1]);
    return MFAS_SEQ[idx];
  endfunction

endpackage

// File: rtl/crc4mf_rst_sync.sv
module crc4mf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/crc4mf_hist.sv
// Sliding history of NFAS bit-1 values with fill tracking.
module crc4mf_hist #(
  parameter int             LEN     = 6,
  parameter logic [LEN-1:0] PATTERN = 6'b001011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic shift_en,
  input  logic bit_in,
  output logic match
);

  localparam int FILL_W = $clog2(LEN + 1);

  logic [LEN-1:0]    hist_q, hist_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [LEN-1:0]    window;

  assign window = {hist_q[LEN-2:0], bit_in};
  assign match  = shift_en && (fill_q >= FILL_W'(LEN - 1)) && (window == PATTERN);

  always_comb begin
    hist_d = hist_q;
    fill_d = fill_q;
    if (clear) begin
      hist_d = '0;
      fill_d = '0;
    end else if (shift_en) begin
      hist_d = window;
      if (fill_q < FILL_W'(LEN)) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_d;
      fill_q <= fill_d;
    end
  end

endmodule

// File: rtl/crc4mf_align.sv
// Search / confirm / synced state machine and multiframe position.
module crc4mf_align
  import crc4mf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             basic_ok,
  input  logic             frame_stb,
  input  logic             nfas_frame,
  input  logic             rx_bit,
  input  logic             cand_match,
  output logic             synced,
  output logic [POS_W-1:0] frame_pos
);

  localparam logic [POS_W-1:0] POS_AFTER = POS_W'(LAST_SEQ_FR + 1);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(LAST_SEQ_FR);

  mf_state_t        st_q, st_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             in_span;

  assign in_span = nfas_frame && pos_q[0] && (pos_q <= POS_LAST);

  always_comb begin
    st_d  = st_q;
    pos_d = pos_q;
    if (!basic_ok) begin
      st_d  = ST_SEARCH;
      pos_d = '0;
    end else if (frame_stb) begin
      unique case (st_q)
        ST_SEARCH: begin
          if (cand_match) begin
            st_d  = ST_CONFIRM;
            pos_d = POS_AFTER;
          end
        end
        ST_CONFIRM: begin
          pos_d = pos_q + 1'b1;
          if (in_span) begin
            if (rx_bit != seq_bit(pos_q)) begin
              // slide: the current NFAS frame may end a new candidate
              if (cand_match) begin
                st_d  = ST_CONFIRM;
                pos_d = POS_AFTER;
              end else begin
                st_d  = ST_SEARCH;
                pos_d = '0;
              end
            end else if (pos_q == POS_LAST) begin
              st_d = ST_SYNCED;
            end
          end
        end
        ST_SYNCED: pos_d = pos_q + 1'b1;
        default: begin
          st_d  = ST_SEARCH;
          pos_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SEARCH;
      pos_q <= '0;
    end else begin
      st_q  <= st_d;
      pos_q <= pos_d;
    end
  end

  assign synced    = (st_q == ST_SYNCED);
  assign frame_pos = pos_q;

endmodule

// File: rtl/crc4mf_iw.sv
// Interworking timer and non-CRC-4 far-end decision.
module crc4mf_iw #(
  parameter int TIMEOUT_FRAMES = 3200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic basic_ok,
  input  logic frame_stb,
  input  logic crc_synced,
  input  logic auto_en,
  input  logic iw_clear,
  output logic far_no_crc4
);

  localparam int            TW    = $clog2(TIMEOUT_FRAMES);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_FRAMES - 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic          far_q, far_d;
  logic          tick;

  assign tick = basic_ok && frame_stb && !crc_synced && !far_q;

  always_comb begin
    tmr_d = tmr_q;
    far_d = far_q;
    if (iw_clear) begin
      tmr_d = '0;
      far_d = 1'b0;
    end else begin
      if (!basic_ok) tmr_d = '0;
      else if (tick && tmr_q != LIMIT) tmr_d = tmr_q + 1'b1;
      if (tick && auto_en && tmr_q == LIMIT) far_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      far_q <= 1'b0;
    end else begin
      tmr_q <= tmr_d;
      far_q <= far_d;
    end
  end

  assign far_no_crc4 = far_q;

endmodule

// File: rtl/e1_crc4_mf_align.sv
module e1_crc4_mf_align
  import crc4mf_pkg::*;
#(
  parameter int TIMEOUT_FRAMES = 3200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       basic_sync_n,
  input  logic       frame_stb,
  input  logic       nfas_frame,
  input  logic       rx_bit,
  input  logic       auto_iw_n,
  input  logic       iw_clear,
  output logic       crc_sync_n,
  output logic [3:0] mf_count,
  output logic       far_no_crc4,
  output logic       rx_crc4_en,
  output logic       tx_ebit_zero
);

  logic             rst_n_s;
  logic             basic_ok;
  logic             cand_match;
  logic             synced;
  logic [POS_W-1:0] frame_pos;
  logic             far;

  assign basic_ok = !basic_sync_n;

  crc4mf_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_s)
  );

  crc4mf_hist #(.LEN(SEQ_LEN), .PATTERN(MFAS_SEQ)) hist_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clear    (!basic_ok),
    .shift_en (basic_ok && frame_stb && nfas_frame),
    .bit_in   (rx_bit),
    .match    (cand_match)
  );

  crc4mf_align align_i (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .basic_ok   (basic_ok),
    .frame_stb  (frame_stb),
    .nfas_frame (nfas_frame),
    .rx_bit     (rx_bit),
    .cand_match (cand_match),
    .synced     (synced),
    .frame_pos  (frame_pos)
  );

  crc4mf_iw #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) iw_i (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .basic_ok    (basic_ok),
    .frame_stb   (frame_stb),
    .crc_synced  (synced),
    .auto_en     (!auto_iw_n),
    .iw_clear    (iw_clear),
    .far_no_crc4 (far)
  );

  assign crc_sync_n   = !synced;
  assign mf_count     = synced ? 4'(frame_pos) : 4'd0;
  assign far_no_crc4  = far;
  assign rx_crc4_en   = synced && !far;
  assign tx_ebit_zero = far;

endmodule

// File: rtl/e1_crc4_mf_align_chk.sv
module e1_crc4_mf_align_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       basic_sync_n,
  input logic       frame_stb,
  input logic       nfas_frame,
  input logic       auto_iw_n,
  input logic       iw_clear,
  input logic       crc_sync_n,
  input logic [3:0] mf_count,
  input logic       far_no_crc4,
  input logic       rx_crc4_en,
  input logic       tx_ebit_zero
);

  assert_sync_at_seq_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crc_sync_n) |-> (mf_count == 4'd12) && $past(frame_stb && nfas_frame));

  assert_mf_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!crc_sync_n && frame_stb && !basic_sync_n) |=> (mf_count == $past(mf_count) + 4'd1));

  assert_basic_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    basic_sync_n |=> (crc_sync_n && mf_count == 4'd0));

  assert_no_search_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (basic_sync_n && crc_sync_n) |=> crc_sync_n);

  assert_ebit_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
    far_no_crc4 |-> (tx_ebit_zero && !rx_crc4_en));

  assert_auto_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(far_no_crc4) |-> $past(!auto_iw_n && frame_stb && !iw_clear));

  assert_decision_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (far_no_crc4 && !iw_clear) |=> far_no_crc4);

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    iw_clear |=> !far_no_crc4);

endmodule

bind e1_crc4_mf_align e1_crc4_mf_align_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .basic_sync_n (basic_sync_n),
  .frame_stb    (frame_stb),
  .nfas_frame   (nfas_frame),
  .auto_iw_n    (auto_iw_n),
  .iw_clear     (iw_clear),
  .crc_sync_n   (crc_sync_n),
  .mf_count     (mf_count),
  .far_no_crc4  (far_no_crc4),
  .rx_crc4_en   (rx_crc4_en),
  .tx_ebit_zero (tx_ebit_zero)
);

// File: tb/e1_crc4_mf_align_tb_top.sv
module e1_crc4_mf_align_tb_top;

  localparam int TIMEOUT = 3200;

  logic       clk;
  logic       rst_n;
  logic       basic_sync_n;
  logic       frame_stb;
  logic       nfas_frame;
  logic       rx_bit;
  logic       auto_iw_n;
  logic       iw_clear;
  logic       crc_sync_n;
  logic [3:0] mf_count;
  logic       far_no_crc4;
  logic       rx_crc4_en;
  logic       tx_ebit_zero;

  int checks;
  int errors;
  int cycles;

  e1_crc4_mf_align #(.TIMEOUT_FRAMES(TIMEOUT)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .basic_sync_n (basic_sync_n),
    .frame_stb    (frame_stb),
    .nfas_frame   (nfas_frame),
    .rx_bit       (rx_bit),
    .auto_iw_n    (auto_iw_n),
    .iw_clear     (iw_clear),
    .crc_sync_n   (crc_sync_n),
    .mf_count     (mf_count),
    .far_no_crc4  (far_no_crc4),
    .rx_crc4_en   (rx_crc4_en),
    .tx_ebit_zero (tx_ebit_zero)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic seq_val(input int f, input int bad);
    logic b;
    if (f % 2 == 1 && f <= 11) b = (6'b001011 >> (5 - f / 2)) & 1'b1;
    else if (f % 2 == 1)        b = 1'b1;
    else                        b = ((f / 2) % 2 == 1);
    if (f == bad) b = ~b;
    return b;
  endfunction

  // one frame: strobe for one cycle, then idle
  task automatic send_frame(input int f, input logic b);
    @(negedge clk);
    frame_stb  = 1'b1;
    nfas_frame = (f % 2 == 1);
    rx_bit     = b;
    @(negedge clk);
    frame_stb  = 1'b0;
    rx_bit     = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_span(input int first, input int last, input int bad);
    for (int f = first; f <= last; f++) send_frame(f, seq_val(f, bad));
  endtask

  task automatic send_blank(input int n);
    for (int i = 0; i < n; i++) send_frame(i % 16, 1'b0);
  endtask

  task automatic drop_basic(input int frames);
    @(negedge clk);
    basic_sync_n = 1'b1;
    @(negedge clk);
    check("R7 sync cleared on basic loss", crc_sync_n, 1);
    check("R7 mf_count zero on basic loss", mf_count, 0);
    for (int i = 0; i < frames; i++) send_frame(i % 16, seq_val(i % 16, -1));
    @(negedge clk);
    basic_sync_n = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 crc_sync_n", crc_sync_n, 1);
    check("R1 mf_count", mf_count, 0);
    check("R1 far_no_crc4", far_no_crc4, 0);
    check("R1 rx_crc4_en", rx_crc4_en, 0);
    check("R1 tx_ebit_zero", tx_ebit_zero, 0);
  endtask

  task automatic t_no_basic;
    for (int m = 0; m < 3; m++) send_span(0, 15, -1);
    check("R2 no sync without basic alignment", crc_sync_n, 1);
  endtask

  task automatic t_align;
    @(negedge clk);
    basic_sync_n = 1'b0;
    send_span(0, 15, -1);
    check("R4 one sequence is not enough", crc_sync_n, 1);
    send_span(0, 10, -1);
    check("R4 not synced before frame 11", crc_sync_n, 1);
    send_span(11, 11, -1);
    check("R4 synced after second frame 11", crc_sync_n, 0);
    check("R6 mf_count after sync", mf_count, 12);
    check("R12 rx_crc4_en in sync", rx_crc4_en, 1);
  endtask

  task automatic t_count;
    for (int k = 0; k < 20; k++) begin
      int f;
      f = (12 + k) % 16;
      send_frame(f, seq_val(f, -1));
      check("R6 mf_count advance", mf_count, (f + 1) % 16);
    end
  endtask

  task automatic t_basic_loss;
    // partial history 1,0,1,1 must not combine with stale zeros
    drop_basic(2);
    send_span(0, 15, -1);
    check("R7 restart needs two sequences", crc_sync_n, 1);
    send_span(0, 15, -1);
    check("R7 resync after two sequences", crc_sync_n, 0);
    check("R6 mf_count wraps to 0", mf_count, 0);
    drop_basic(0);
    send_frame(5, 1'b1);
    send_frame(7, 1'b0);
    send_frame(9, 1'b1);
    send_frame(11, 1'b1);
    send_span(12, 15, -1);
    send_span(0, 11, -1);
    check("R7 no match on partial history", crc_sync_n, 1);
    send_span(12, 15, -1);
    send_span(0, 15, -1);
    check("R7 sync after full sequences", crc_sync_n, 0);
  endtask

  task automatic t_nonconsec;
    drop_basic(0);
    send_span(0, 15, -1);
    send_span(0, 15, 5);
    check("R5 error in second sequence", crc_sync_n, 1);
    send_span(0, 15, -1);
    check("R5 one clean sequence after error", crc_sync_n, 1);
    send_span(0, 15, -1);
    check("R5 sync after two consecutive", crc_sync_n, 0);
  endtask

  task automatic t_ignored_bits;
    // E-bit frames and FAS frames carry flipped values
    drop_basic(0);
    for (int m = 0; m < 2; m++) begin
      for (int f = 0; f < 16; f++) begin
        logic b;
        b = seq_val(f, -1);
        if (f % 2 == 0 || f > 11) b = (m == 0) ? ~b : 1'b0;
        send_frame(f, b);
      end
    end
    check("R3 E and FAS bits ignored", crc_sync_n, 0);
  endtask

  task automatic t_auto_off;
    drop_basic(0);
    auto_iw_n = 1'b1;
    send_blank(TIMEOUT + 100);
    check("R10 no decision with auto off", far_no_crc4, 0);
    auto_iw_n = 1'b0;
  endtask

  task automatic t_timeout;
    drop_basic(0);
    send_blank(TIMEOUT - 1);
    check("R8 no decision before limit", far_no_crc4, 0);
    send_frame(0, 1'b0);
    check("R8 decision at limit", far_no_crc4, 1);
    check("R9 tx_ebit_zero", tx_ebit_zero, 1);
    check("R9 rx_crc4_en off", rx_crc4_en, 0);
  endtask

  task automatic t_hold_clear;
    drop_basic(4);
    check("R11 decision kept over basic loss", far_no_crc4, 1);
    @(negedge clk);
    iw_clear = 1'b1;
    @(negedge clk);
    iw_clear = 1'b0;
    check("R11 decision cleared", far_no_crc4, 0);
    send_span(0, 15, -1);
    send_span(0, 15, -1);
    check("R12 sync in period", crc_sync_n, 0);
    for (int i = 0; i < TIMEOUT + 100; i++) send_frame(i % 16, seq_val(i % 16, -1));
    check("R12 no decision after sync", far_no_crc4, 0);
    check("R12 rx_crc4_en stays on", rx_crc4_en, 1);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    basic_sync_n = 1'b1;
    frame_stb = 1'b0;
    nfas_frame = 1'b0;
    rx_bit = 1'b0;
    auto_iw_n = 1'b0;
    iw_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_no_basic();
    t_align();
    t_count();
    t_basic_loss();
    t_nonconsec();
    t_ignored_bits();
    t_auto_off();
    t_timeout();
    t_hold_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

endmodule